// File: doc/BRIEF.md
# Two-Stage Fetch Unit with Taken-Branch Annulment

This block is the instruction sequencer for a 32-bit RISC core with two pipeline stages, fetch and execute. It holds the fetch address and advances it by one word each cycle. It latches each fetched word into an execute-stage instruction register, and it resolves conditional branches while they sit in execute. A branch tests only whether the value of its Ra operand is zero. Because the decision is made one stage after fetch, exactly one following instruction, the delay slot, has already been fetched when a branch resolves.

When a branch resolves as taken, the unit replaces the delay-slot word with an encoded no-operation. It also drops the write permissions for the register file and data memory for that slot. When the branch is not taken, the delay-slot instruction continues normally. The register file, ALU and memories are outside the block. The surrounding datapath reads the register named by `ex_ra_idx` and returns its value on `ra_value`. It gates its write enables with `rf_wr_allow` and `mem_wr_allow`.

Top module: `branch_annul_fetch`

## Requirements
- R1: A synchronous active-high reset sets `pc_out` to 0, loads the no-op word 32'h83FFF800 (opcode 6'h20 in bits 31:26, register fields 25:21, 20:16 and 15:11 all equal to 31, low bits zero) into `ex_inst`, and holds `rf_wr_allow` and `mem_wr_allow` low.
- R2: When no taken branch is in execute, `next_pc` equals `pc_out + 4`. At the next edge `pc_out` takes that value, `ex_inst` takes `fetch_word`, and `ex_pc` takes the old `pc_out`.
- R3: An execute-stage word with opcode 6'h1D (bits 31:26) is taken exactly when `ra_value` is zero. Opcode 6'h1E is taken exactly when `ra_value` is nonzero. No other opcode ever redirects fetch.
- R4: The target of a taken branch is `ex_pc + 4` plus the sign-extended literal in bits 15:0 shifted left by two, modulo 2^32. It appears on `next_pc` in the same cycle and on `pc_out` after the edge.
- R5: On a taken branch, the next `ex_inst` is the no-op word 32'h83FFF800 instead of the fetched delay-slot word.
- R6: `rf_wr_allow` and `mem_wr_allow` are high while a live instruction is in execute, and low while an annulled slot or the reset bubble occupies it.
- R7: `ex_ra_idx` carries bits 20:16 of `ex_inst`.
- R8: An annulled or reset slot never redirects fetch, even when the fetched word it replaced was itself a branch whose condition holds.
- R9: In a loop closed by a taken backward branch, the delay-slot instruction has its write permission only on the final pass, when the branch falls through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | 32 | Instruction word read at `pc_out` |
| ra_value | input | 32 | Register value for the Ra field of the execute instruction |
| pc_out | output | 32 | Current fetch address |
| next_pc | output | 32 | Fetch address for the following cycle |
| ex_inst | output | 32 | Execute-stage instruction register |
| ex_pc | output | 32 | Address of the execute-stage instruction |
| ex_ra_idx | output | 5 | Ra register index of the execute instruction |
| rf_wr_allow | output | 1 | Register-file write permission for the execute slot |
| mem_wr_allow | output | 1 | Data-memory write permission for the execute slot |

## Verification
The branch decision and `next_pc` are combinational on `ex_inst` and `ra_value`. The bench therefore checks them one time step after driving the inputs, in the same cycle and before the clock edge. `pc_out`, `ex_inst`, `ex_pc` and the write permissions pass through one register, so they are checked just after the next rising edge. The first instruction after a branch is checked one edge later again, which is when the annulled slot's own effect on `next_pc` shows. The sweep drives new inputs only after that post-edge check, so each sample belongs to exactly one stimulus.

// File: rtl/bafu_pkg.sv
package bafu_pkg;

   localparam int INST_W = 32;
   localparam int OPC_W  = 6;
   localparam int REG_W  = 5;
   localparam int LIT_W  = 16;

   localparam int OPC_LSB = 26;
   localparam int RC_LSB  = 21;
   localparam int RA_LSB  = 16;
   localparam int RB_LSB  = 11;

   localparam int WORD_BYTES = 4;
   localparam int WORD_SHIFT = 2;

   typedef logic [INST_W-1:0] inst_t;
   typedef logic [OPC_W-1:0]  opc_t;

   localparam opc_t OPC_BRZ  = 6'h1D;
   localparam opc_t OPC_BRNZ = 6'h1E;
   localparam opc_t OPC_ADD  = 6'h20;

   localparam logic [REG_W-1:0] ZERO_REG = 5'd31;

   localparam inst_t NOP_WORD = {OPC_ADD, ZERO_REG, ZERO_REG, ZERO_REG, 11'd0};

   typedef enum logic [1:0] {
      BR_NONE    = 2'd0,
      BR_ZERO    = 2'd1,
      BR_NONZERO = 2'd2
   } br_kind_e;

   function automatic br_kind_e branch_kind(input opc_t op);
      case (op)
         OPC_BRZ:  return BR_ZERO;
         OPC_BRNZ: return BR_NONZERO;
         default:  return BR_NONE;
      endcase
   endfunction

endpackage

// File: rtl/bafu_pc_seq.sv
module bafu_pc_seq
   import bafu_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] next_pc
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] seq_pc;

   assign seq_pc  = pc_q + STEP;
   assign next_pc = redirect ? target : seq_pc;
   assign pc      = pc_q;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= next_pc;
   end

endmodule

// File: rtl/bafu_exec_reg.sv
module bafu_exec_reg
   import bafu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit LINK_STORE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              annul,
   input  inst_t             fetch_word,
   input  logic [ADDR_W-1:0] fetch_pc,
   output inst_t             ex_inst,
   output logic [ADDR_W-1:0] ex_pc,
   output logic [ADDR_W-1:0] ex_link,
   output logic              ex_live
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   inst_t inst_q;
   logic  live_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         inst_q <= NOP_WORD;
         live_q <= 1'b0;
      end else begin
         inst_q <= annul ? NOP_WORD : fetch_word;
         live_q <= ~annul;
      end
   end

   generate
      if (LINK_STORE) begin : g_store_link
         logic [ADDR_W-1:0] link_q;
         always_ff @(posedge clk) begin
            if (rst) link_q <= STEP;
            else     link_q <= fetch_pc + STEP;
         end
         assign ex_link = link_q;
         assign ex_pc   = link_q - STEP;
      end else begin : g_store_pc
         logic [ADDR_W-1:0] pc_q;
         always_ff @(posedge clk) begin
            if (rst) pc_q <= '0;
            else     pc_q <= fetch_pc;
         end
         assign ex_pc   = pc_q;
         assign ex_link = pc_q + STEP;
      end
   endgenerate

   assign ex_inst = inst_q;
   assign ex_live = live_q;

endmodule

// File: rtl/bafu_branch_eval.sv
module bafu_branch_eval
   import bafu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  opc_t              opcode,
   input  logic [LIT_W-1:0]  literal,
   input  logic              live,
   input  logic [DATA_W-1:0] ra_value,
   input  logic [ADDR_W-1:0] link,
   output logic              taken,
   output logic [ADDR_W-1:0] target
);

   localparam int EXT_W = ADDR_W - LIT_W - WORD_SHIFT;

   br_kind_e          kind;
   logic              is_zero;
   logic [ADDR_W-1:0] byte_off;

   assign kind    = branch_kind(opcode);
   assign is_zero = ~|ra_value;

   always_comb begin
      case (kind)
         BR_ZERO:    taken = live & is_zero;
         BR_NONZERO: taken = live & ~is_zero;
         default:    taken = 1'b0;
      endcase
   end

   generate
      if (EXT_W > 0) begin : g_ext
         assign byte_off = {{EXT_W{literal[LIT_W-1]}}, literal, {WORD_SHIFT{1'b0}}};
      end else begin : g_noext
         assign byte_off = {literal, {WORD_SHIFT{1'b0}}};
      end
   endgenerate

   assign target = link + byte_off;

endmodule

// File: rtl/branch_annul_fetch.sv
module branch_annul_fetch
   import bafu_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 32,
   parameter bit                LINK_STORE = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [31:0]       fetch_word,
   input  logic [DATA_W-1:0] ra_value,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] next_pc,
   output logic [31:0]       ex_inst,
   output logic [ADDR_W-1:0] ex_pc,
   output logic [4:0]        ex_ra_idx,
   output logic              rf_wr_allow,
   output logic              mem_wr_allow
);

   generate
      if (ADDR_W != LIT_W + WORD_SHIFT + 14 && ADDR_W < LIT_W + WORD_SHIFT) begin : g_bad_addr
         $error("ADDR_W too narrow for branch offset");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
      if (RESET_PC[WORD_SHIFT-1:0] != '0) begin : g_bad_reset
         $error("RESET_PC must be word aligned");
      end
   endgenerate

   logic              taken;
   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] link;
   logic              live;
   inst_t             ex_q;

   bafu_pc_seq #(
      .ADDR_W   (ADDR_W),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk      (clk),
      .rst      (rst),
      .redirect (taken),
      .target   (target),
      .pc       (pc_out),
      .next_pc  (next_pc)
   );

   bafu_exec_reg #(
      .ADDR_W     (ADDR_W),
      .LINK_STORE (LINK_STORE)
   ) u_exreg (
      .clk        (clk),
      .rst        (rst),
      .annul      (taken),
      .fetch_word (fetch_word),
      .fetch_pc   (pc_out),
      .ex_inst    (ex_q),
      .ex_pc      (ex_pc),
      .ex_link    (link),
      .ex_live    (live)
   );

   bafu_branch_eval #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_br (
      .opcode   (ex_q[OPC_LSB +: OPC_W]),
      .literal  (ex_q[LIT_W-1:0]),
      .live     (live),
      .ra_value (ra_value),
      .link     (link),
      .taken    (taken),
      .target   (target)
   );

   assign ex_inst      = ex_q;
   assign ex_ra_idx    = ex_q[RA_LSB +: REG_W];
   assign rf_wr_allow  = live;
   assign mem_wr_allow = live;

endmodule

// File: rtl/bafu_checker.sv
module bafu_checker
   import bafu_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] ra_value,
   input logic [ADDR_W-1:0] pc_out,
   input logic [ADDR_W-1:0] next_pc,
   input logic [31:0]       ex_inst,
   input logic [ADDR_W-1:0] ex_pc,
   input logic              rf_wr_allow,
   input logic              mem_wr_allow
);

   logic              seen_taken;
   logic [ADDR_W-1:0] want_off;
   opc_t              op;

   assign op = ex_inst[31:26];
   assign seen_taken = rf_wr_allow &&
                       ((op == OPC_BRZ  && ra_value == '0) ||
                        (op == OPC_BRNZ && ra_value != '0));
   assign want_off = ADDR_W'({{(ADDR_W-18){ex_inst[15]}}, ex_inst[15:0], 2'b00});

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (pc_out == RESET_PC && ex_inst == NOP_WORD && !rf_wr_allow && !mem_wr_allow));

   a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
      !seen_taken |=> (pc_out == $past(pc_out) + ADDR_W'(4) && ex_pc == $past(pc_out)));

   a_r4_target: assert property (@(posedge clk) disable iff (rst)
      seen_taken |=> (pc_out == $past(ex_pc) + ADDR_W'(4) + $past(want_off)));

   a_r5_annul_slot: assert property (@(posedge clk) disable iff (rst)
      seen_taken |=> (ex_inst == NOP_WORD && !rf_wr_allow && !mem_wr_allow));

   a_r8_bubble_inert: assert property (@(posedge clk) disable iff (rst)
      !rf_wr_allow |-> (next_pc == pc_out + ADDR_W'(4)));

endmodule

bind branch_annul_fetch bafu_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .RESET_PC (RESET_PC)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .ra_value     (ra_value),
   .pc_out       (pc_out),
   .next_pc      (next_pc),
   .ex_inst      (ex_inst),
   .ex_pc        (ex_pc),
   .rf_wr_allow  (rf_wr_allow),
   .mem_wr_allow (mem_wr_allow)
);

// File: tb/tb_branch_annul_fetch.sv
module tb_branch_annul_fetch;

   localparam logic [5:0]  OP_BZ  = 6'h1D;
   localparam logic [5:0]  OP_BNZ = 6'h1E;
   localparam logic [5:0]  OP_ADD = 6'h20;
   localparam logic [31:0] NOP    = 32'h83FFF800;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] fw_drv;
   logic [31:0] fetch_word;
   logic [31:0] ra_value;
   logic [31:0] pc_out, next_pc, ex_inst, ex_pc;
   logic [4:0]  ex_ra_idx;
   logic        rf_wr_allow, mem_wr_allow;
   logic        loop_mode;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rc, logic [4:0] ra,
                                      logic [15:0] lit);
      return {op, rc, ra, lit};
   endfunction

   localparam logic [31:0] LOOP_BR = {OP_BNZ, 5'd31, 5'd4, 16'hFFFD};
   localparam logic [31:0] MARK    = {OP_ADD, 5'd9, 5'd9, 16'h0011};

   function automatic logic [31:0] imem(logic [31:0] a);
      case (a)
         32'd8:   return LOOP_BR;
         32'd12:  return MARK;
         default: return {OP_ADD, 5'd1, 5'd1, 16'h0800};
      endcase
   endfunction

   assign fetch_word = loop_mode ? imem(pc_out) : fw_drv;

   branch_annul_fetch dut (
      .clk          (clk),
      .rst          (rst),
      .fetch_word   (fetch_word),
      .ra_value     (ra_value),
      .pc_out       (pc_out),
      .next_pc      (next_pc),
      .ex_inst      (ex_inst),
      .ex_pc        (ex_pc),
      .ex_ra_idx    (ex_ra_idx),
      .rf_wr_allow  (rf_wr_allow),
      .mem_wr_allow (mem_wr_allow)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      fw_drv = mk(OP_ADD, 5'd1, 5'd2, 16'h0);
      ra_value = '0;
      tick();
      tick();
      rst = 1'b0;
   endtask

   task automatic run_case(int k, logic [5:0] op, logic [31:0] rav, logic [15:0] off);
      logic [31:0] bpc, tgt, br, dly;
      bit taken;
      do_reset();
      for (int i = 0; i < k; i++) begin
         fw_drv = mk(OP_ADD, 5'd1, 5'd2, 16'h0);
         tick();
      end
      bpc = 32'(4 * k);
      br  = mk(op, 5'd31, 5'd3, off);
      dly = mk(OP_BZ, 5'd5, 5'd7, 16'h0004);
      fw_drv = br;
      #1;
      chk("R2 sequential next_pc", next_pc, bpc + 4);
      tick();
      chk("R2 ex_inst loaded", ex_inst, br);
      chk("R2 ex_pc", ex_pc, bpc);
      chk("R7 ra index", {27'd0, ex_ra_idx}, 32'd3);
      chk("R6 live write allow", {31'd0, rf_wr_allow}, 32'd1);
      taken = (op == OP_BZ && rav == 0) || (op == OP_BNZ && rav != 0);
      tgt = bpc + 4 + {{14{off[15]}}, off, 2'b00};
      ra_value = rav;
      fw_drv = dly;
      #1;
      chk(taken ? "R3 R4 taken target" : "R3 not taken", next_pc, taken ? tgt : bpc + 8);
      tick();
      chk("R4 pc after branch", pc_out, taken ? tgt : bpc + 8);
      chk("R5 slot word", ex_inst, taken ? NOP : dly);
      chk("R2 slot pc", ex_pc, bpc + 4);
      chk("R6 rf allow", {31'd0, rf_wr_allow}, {31'd0, !taken});
      chk("R6 mem allow", {31'd0, mem_wr_allow}, {31'd0, !taken});
      ra_value = '0;
      fw_drv = mk(OP_ADD, 5'd1, 5'd2, 16'h0);
      #1;
      if (taken) chk("R8 annulled slot inert", next_pc, pc_out + 4);
      else       chk("R3 slot branch taken", next_pc, bpc + 24);
   endtask

   initial begin
      logic [5:0]  ops  [3];
      logic [31:0] ravs [3];
      logic [15:0] offs [6];
      int remaining, slot_live, slot_dead, br_taken;
      ops  = '{OP_ADD, OP_BZ, OP_BNZ};
      ravs = '{32'h0, 32'h1, 32'h8000_0000};
      offs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'hFFFD};
      loop_mode = 1'b0;

      do_reset();
      chk("R1 reset pc", pc_out, 32'h0);
      chk("R1 reset ex_inst", ex_inst, NOP);
      chk("R1 reset rf allow", {31'd0, rf_wr_allow}, 32'd0);
      chk("R1 reset mem allow", {31'd0, mem_wr_allow}, 32'd0);
      fw_drv = mk(OP_BZ, 5'd0, 5'd0, 16'h0040);
      ra_value = '0;
      #1;
      chk("R8 reset bubble inert", next_pc, 32'd4);

      for (int k = 0; k < 3; k++)
         for (int o = 0; o < 3; o++)
            for (int r = 0; r < 3; r++)
               for (int f = 0; f < 6; f++)
                  run_case(k, ops[o], ravs[r], offs[f]);

      // R9 loop with backward taken branch
      do_reset();
      loop_mode = 1'b1;
      remaining = 4;
      slot_live = 0;
      slot_dead = 0;
      br_taken  = 0;
      ra_value  = '0;
      for (int c = 0; c < 40; c++) begin
         if (ex_pc == 32'd12 && c > 0) begin
            if (rf_wr_allow) begin
               slot_live++;
               chk("R9 live slot word", ex_inst, MARK);
            end else begin
               slot_dead++;
               chk("R9 annulled slot word", ex_inst, NOP);
               chk("R9 annulled mem allow", {31'd0, mem_wr_allow}, 32'd0);
            end
         end
         if (ex_inst == LOOP_BR && rf_wr_allow) begin
            chk("R7 loop ra index", {27'd0, ex_ra_idx}, 32'd4);
            ra_value = (remaining > 0) ? 32'd1 : 32'd0;
            #1;
            if (remaining > 0) begin
               br_taken++;
               remaining--;
               chk("R4 backward target", next_pc, 32'd0);
            end else begin
               chk("R3 loop exit", next_pc, 32'd16);
            end
         end
         tick();
      end
      chk("R9 taken count", 32'(br_taken), 32'd4);
      chk("R9 annulled slots", 32'(slot_dead), 32'd4);
      chk("R9 live slot once", 32'(slot_live), 32'd1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule